// File: doc/BRIEF.md
# Dual-channel system timer

This peripheral holds two timing channels behind a 32-bit register bus, and both channels run from one input clock. The first channel is a one-shot event timer. Software loads a compare value and starts the channel. When the count reaches the compare value, the channel raises a flag, drives an interrupt unless the interrupt is masked, and stops itself. The second channel is a free-running 64-bit counter that software reads as a time base. A read of its lower word captures the upper word into a buffer, so that the two reads together give one consistent 64-bit value.

Each channel has its own power-of-four prescaler, built as a tick enable in the single clock domain. Channels start through a write-one-to-set enable register and stop through a separate write-one-to-clear register. A command register zeroes either counter. Read data is combinational on the address. A write or a read strobe acts on the rising clock edge at which it is sampled.

Top module: `duo_timer`

## Requirements
- R1: After reset every register reads zero except the mask register at 0x10, whose bit 0 reads 1. The interrupt output is low.
- R2: The prescale register at 0x00 holds the channel 1 field in bits [1:0] and the channel 2 field in bits [3:2]. Other bits are dropped on write and read as zero. A field value v divides the input clock by 4^v, so 0, 1, 2 and 3 give /1, /4, /16 and /64. A started channel counts one step per divided period, and its first step comes a full period after the start edge.
- R3: A write that changes a channel's prescale field restarts that channel's divider from zero on the write edge.
- R4: Writing 1 to bit 0 of the command register at 0x08 zeroes the channel 1 count. Writing 1 to bit 1 zeroes the whole 64-bit channel 2 count. A 0 in either bit has no effect.
- R5: Writing 1 to bit 0 or bit 1 of 0x34 starts channel 1 or channel 2. Writing 1 to the same bit of 0x38 stops that channel. 0x34 reads back the two enable bits, and 0x38 reads zero.
- R6: Channel 1 counts up from its current count toward the compare value at 0x14. On the tick where the count equals the compare value, the flag at 0x0C bit 0 sets, the channel clears its own enable, and the count holds at the compare value. Counting from 0 with compare N, the flag sets N+1 ticks after the start.
- R7: Compare values of 4 and 0xFFFFFFFF both match correctly. The channel 1 count at 0x18 can be written to preload it.
- R8: Writing 0 to bit 0 of 0x0C clears the flag, and writing 1 leaves it unchanged. A match in the same cycle as a clear leaves the flag set.
- R9: The interrupt output equals the flag while mask bit 0 at 0x10 is 0, and it is low while that bit is 1.
- R10: Channel 2 is a 64-bit counter. Its lower word at 0x20 wraps modulo 2^32 and carries into the upper half. Writing 0x20 loads the lower 32 bits and keeps the upper half.
- R11: A read of 0x20 copies the upper 32 bits of the channel 2 count, as it stood in that same cycle, into the buffer at 0x24. The buffer keeps this value until the next read of 0x20.
- R12: Reads from unmapped offsets return zero, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock shared by both channels |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; triggers the high-word capture on a read of 0x20 |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq_o | output | 1 | Channel 1 interrupt, the flag gated by the mask |

## Verification
A divider that restarts in the wrong place or at the wrong time shifts the count read from 0x18 or 0x20 by one step within a single divided period. The bench reads these counts at edge counts chosen on both sides of each step. A wrong compare or stop state shows on irq_o one tick early or late, or as a count that keeps moving after the match. A stale high buffer shows on the first read of 0x24 after the lower word wraps.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;
   // register offsets; the software view depends on these values
   localparam int unsigned OFS_PSC  = 'h00;
   localparam int unsigned OFS_CLR  = 'h08;
   localparam int unsigned OFS_FLG  = 'h0C;
   localparam int unsigned OFS_MSK  = 'h10;
   localparam int unsigned OFS_CMP  = 'h14;
   localparam int unsigned OFS_CNT1 = 'h18;
   localparam int unsigned OFS_LO2  = 'h20;
   localparam int unsigned OFS_HI2  = 'h24;
   localparam int unsigned OFS_ENS  = 'h34;
   localparam int unsigned OFS_ENC  = 'h38;

   localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/duo_tick_gen.sv
module duo_tick_gen #(
   parameter int unsigned PSC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);
   localparam int unsigned DIV_W = 2 * ((1 << PSC_W) - 1);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] last_val;

   // terminal count of 4^psc - 1
   assign last_val = (DIV_W'(1) << {psc, 1'b0}) - DIV_W'(1);
   assign tick     = run & ~restart & (div_q == last_val);

   always_ff @(posedge clk) begin
      if (!rst_n)                      div_q <= '0;
      else if (!run || restart || tick) div_q <= '0;
      else                              div_q <= div_q + DIV_W'(1);
   end

   // R2: with a non-unit divider two ticks never come back to back
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && psc != '0) |=> (!tick || psc == '0));

   // R3: a restart leaves the divider at zero
   assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (div_q == '0));
endmodule

// File: rtl/duo_oneshot.sv
module duo_oneshot #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] cmp,
   output logic [W-1:0] cnt,
   output logic         hit
);
   assign hit = tick & (cnt == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (ld)         cnt <= ld_val;
      else if (tick && !hit) cnt <= cnt + W'(1);
   end

   // R6: the count holds on the matching tick
   assert_hold_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr && !ld) |=> (cnt == $past(cnt)));

   // R6: a non-matching tick advances the count by one
   assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hit && !clr && !ld) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/duo_freerun.sv
module duo_freerun #(
   parameter int unsigned W    = 64,
   parameter int unsigned LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clr,
   input  logic            ld_lo,
   input  logic [LO_W-1:0] ld_val,
   output logic [W-1:0]    cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (ld_lo) cnt <= {cnt[W-1:LO_W], ld_val};
      else if (tick)  cnt <= cnt + W'(1);
   end

   // R10: a lower-word load keeps the upper half
   assert_lo_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_lo && !clr) |=> (cnt[LO_W-1:0] == $past(ld_val) &&
                           cnt[W-1:LO_W] == $past(cnt[W-1:LO_W])));

   // R4: a clear command leaves the full count at zero
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/duo_timer.sv
module duo_timer
   import duo_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FREE_W = 64,
   parameter int unsigned PSC_W  = 2,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int unsigned HI_W = FREE_W - DATA_W;

   if (FREE_W != 2 * DATA_W) begin : g_bad_free
      $error("duo_timer: FREE_W must be twice DATA_W");
   end
   if (PSC_W < 1 || PSC_W > 3) begin : g_bad_psc
      $error("duo_timer: PSC_W must lie in 1..3");
   end
   if (DATA_W < 2 * PSC_W || ADDR_W < 6) begin : g_bad_bus
      $error("duo_timer: bus too narrow for the register map");
   end

   // decoded strobes
   logic wr_psc, wr_clr, wr_flg, wr_msk, wr_cmp, wr_cnt1, wr_lo2, wr_ens, wr_enc, rd_lo2;
   assign wr_psc  = bus_wr && bus_addr == ADDR_W'(OFS_PSC);
   assign wr_clr  = bus_wr && bus_addr == ADDR_W'(OFS_CLR);
   assign wr_flg  = bus_wr && bus_addr == ADDR_W'(OFS_FLG);
   assign wr_msk  = bus_wr && bus_addr == ADDR_W'(OFS_MSK);
   assign wr_cmp  = bus_wr && bus_addr == ADDR_W'(OFS_CMP);
   assign wr_cnt1 = bus_wr && bus_addr == ADDR_W'(OFS_CNT1);
   assign wr_lo2  = bus_wr && bus_addr == ADDR_W'(OFS_LO2);
   assign wr_ens  = bus_wr && bus_addr == ADDR_W'(OFS_ENS);
   assign wr_enc  = bus_wr && bus_addr == ADDR_W'(OFS_ENC);
   assign rd_lo2  = bus_rd && bus_addr == ADDR_W'(OFS_LO2);

   // state
   logic [NUM_CH-1:0][PSC_W-1:0] psc_q;
   logic [NUM_CH-1:0]            en_q;
   logic [NUM_CH-1:0]            restart;
   logic [NUM_CH-1:0]            tick;
   logic [NUM_CH-1:0]            clr_cmd;
   logic                         flag_q, mask_q;
   logic [DATA_W-1:0]            cmp_q;
   logic [HI_W-1:0]              hbuf_q;
   logic [DATA_W-1:0]            cnt1;
   logic [FREE_W-1:0]            cnt2;
   logic                         hit1;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign clr_cmd[ch] = wr_clr && bus_wdata[ch];
      assign restart[ch] = clr_cmd[ch] ||
                           (wr_psc && bus_wdata[ch*PSC_W +: PSC_W] != psc_q[ch]);

      always_ff @(posedge clk) begin
         if (!rst_n)      psc_q[ch] <= '0;
         else if (wr_psc) psc_q[ch] <= bus_wdata[ch*PSC_W +: PSC_W];
      end

      duo_tick_gen #(.PSC_W(PSC_W)) u_tick (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (en_q[ch]),
         .restart (restart[ch]),
         .psc     (psc_q[ch]),
         .tick    (tick[ch])
      );
   end

   duo_oneshot #(.W(DATA_W)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick[0]),
      .clr    (clr_cmd[0]),
      .ld     (wr_cnt1),
      .ld_val (bus_wdata),
      .cmp    (cmp_q),
      .cnt    (cnt1),
      .hit    (hit1)
   );

   duo_freerun #(.W(FREE_W), .LO_W(DATA_W)) u_src (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick[1]),
      .clr    (clr_cmd[1]),
      .ld_lo  (wr_lo2),
      .ld_val (bus_wdata),
      .cnt    (cnt2)
   );

   // enables: set beats clear; channel 1 also stops itself on a match
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else begin
         if (wr_ens && bus_wdata[0])                 en_q[0] <= 1'b1;
         else if ((wr_enc && bus_wdata[0]) || hit1)  en_q[0] <= 1'b0;
         if (wr_ens && bus_wdata[1])                 en_q[1] <= 1'b1;
         else if (wr_enc && bus_wdata[1])            en_q[1] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         mask_q <= 1'b1;
         cmp_q  <= '0;
         hbuf_q <= '0;
      end else begin
         if (hit1)                          flag_q <= 1'b1;
         else if (wr_flg && !bus_wdata[0])  flag_q <= 1'b0;
         if (wr_msk) mask_q <= bus_wdata[0];
         if (wr_cmp) cmp_q  <= bus_wdata;
         if (rd_lo2) hbuf_q <= cnt2[FREE_W-1:DATA_W];
      end
   end

   assign irq_o = flag_q & ~mask_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_PSC):  bus_rdata[2*PSC_W-1:0] = {psc_q[1], psc_q[0]};
         ADDR_W'(OFS_FLG):  bus_rdata[0] = flag_q;
         ADDR_W'(OFS_MSK):  bus_rdata[0] = mask_q;
         ADDR_W'(OFS_CMP):  bus_rdata = cmp_q;
         ADDR_W'(OFS_CNT1): bus_rdata = cnt1;
         ADDR_W'(OFS_LO2):  bus_rdata = cnt2[DATA_W-1:0];
         ADDR_W'(OFS_HI2):  bus_rdata = hbuf_q;
         ADDR_W'(OFS_ENS):  bus_rdata[NUM_CH-1:0] = en_q;
         default:           bus_rdata = '0;
      endcase
   end

   // R6: the flag only rises after a compare match
   assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(hit1));

   // R6: a match stops channel 1 unless a start arrives in the same cycle
   assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit1 && !(wr_ens && bus_wdata[0])) |=> !en_q[0]);

   // R11: a lower-word read captures the upper half of that cycle
   assert_hbuf_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo2 |=> (hbuf_q == $past(cnt2[FREE_W-1:DATA_W])));

   // R9: a set mask keeps the interrupt low in the following cycle
   assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_msk && bus_wdata[0]) |=> !irq_o);
endmodule

// File: tb/duo_timer_test.sv
module duo_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   duo_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   localparam logic [7:0] A_PSC = 8'h00, A_CLR = 8'h08, A_FLG = 8'h0C, A_MSK = 8'h10,
                          A_CMP = 8'h14, A_CNT1 = 8'h18, A_LO2 = 8'h20, A_HI2 = 8'h24,
                          A_ENS = 8'h34, A_ENC = 8'h38;

   // channel 2 prescale table: field value, edges waited, expected count
   localparam int NV = 7;
   localparam int VEC [NV][3] = '{
      '{0, 7, 7}, '{1, 9, 2}, '{1, 12, 3}, '{2, 31, 1},
      '{2, 32, 2}, '{3, 63, 0}, '{3, 64, 1}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // tasks start and end at a falling edge; each spans one rising edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic irq_is(input string req, input logic exp);
      #1 check(req, {31'b0, irq_o}, {31'b0, exp});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v, a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      rd(A_PSC, v);  check("R1 psc", v, 0);
      rd(A_FLG, v);  check("R1 flag", v, 0);
      rd(A_MSK, v);  check("R1 mask", v, 1);
      rd(A_CMP, v);  check("R1 cmp", v, 0);
      rd(A_CNT1, v); check("R1 cnt1", v, 0);
      rd(A_LO2, v);  check("R1 lo2", v, 0);
      rd(A_HI2, v);  check("R1 hi2", v, 0);
      rd(A_ENS, v);  check("R1 enables", v, 0);
      irq_is("R1 irq", 1'b0);

      // R2: channel 2 prescale table
      for (int i = 0; i < NV; i++) begin
         wr(A_ENC, 32'h2);
         wr(A_PSC, 32'(VEC[i][0]) << 2);
         wr(A_CLR, 32'h2);
         wr(A_ENS, 32'h2);
         repeat (VEC[i][1]) @(negedge clk);
         rd(A_LO2, v);
         check($sformatf("R2 vec%0d", i), v, 32'(VEC[i][2]));
      end

      // R10 / R11: wrap and coherent high word
      wr(A_ENC, 32'h2);
      wr(A_PSC, 32'h0);
      wr(A_CLR, 32'h2);
      wr(A_ENS, 32'h2);
      wr(A_LO2, 32'hFFFF_FFFE);
      rd(A_LO2, v); check("R10 load", v, 32'hFFFF_FFFE);
      rd(A_HI2, v); check("R11 hi before wrap", v, 0);
      rd(A_LO2, v); check("R10 wrap low", v, 0);
      rd(A_HI2, v); check("R11 hi after wrap", v, 1);
      rd(A_HI2, v); check("R11 hi held", v, 1);

      // R5: stop; R4: zero bits ignored, then clear
      wr(A_ENC, 32'h2);
      rd(A_LO2, a);
      repeat (5) @(negedge clk);
      rd(A_LO2, v); check("R5 stopped", v, a);
      wr(A_CLR, 32'h0);
      rd(A_LO2, v); check("R4 zero no effect", v, a);
      wr(A_CLR, 32'h2);
      rd(A_LO2, v); check("R4 clear low", v, 0);
      rd(A_HI2, v); check("R4 clear high", v, 0);

      // R6 / R9: compare 4 from zero -> flag on 5th tick
      wr(A_MSK, 32'h0);
      wr(A_CMP, 32'd4);
      wr(A_CLR, 32'h1);
      wr(A_ENS, 32'h1);
      repeat (4) @(negedge clk);
      irq_is("R6 no early match", 1'b0);
      @(negedge clk);
      irq_is("R6 match", 1'b1);
      rd(A_FLG, v);  check("R6 flag", v, 1);
      rd(A_CNT1, v); check("R6 count held", v, 4);
      rd(A_ENS, v);  check("R6 self stop", v, 0);

      // R9: mask
      wr(A_MSK, 32'h1);
      irq_is("R9 masked", 1'b0);
      wr(A_MSK, 32'h0);
      irq_is("R9 unmasked", 1'b1);

      // R8: flag clear by writing zero
      wr(A_FLG, 32'h1);
      rd(A_FLG, v); check("R8 write one keeps", v, 1);
      wr(A_FLG, 32'h0);
      rd(A_FLG, v); check("R8 write zero clears", v, 0);
      irq_is("R8 irq low", 1'b0);

      // R7: largest compare via preload
      wr(A_CNT1, 32'hFFFF_FFFC);
      wr(A_CMP, 32'hFFFF_FFFF);
      wr(A_ENS, 32'h1);
      repeat (3) @(negedge clk);
      irq_is("R7 no early match", 1'b0);
      @(negedge clk);
      irq_is("R7 match at max", 1'b1);
      rd(A_CNT1, v); check("R7 count", v, 32'hFFFF_FFFF);
      wr(A_FLG, 32'h0);

      // R3: prescale change restarts the divider
      wr(A_CMP, 32'd100);
      wr(A_CLR, 32'h1);
      wr(A_PSC, 32'h1);
      wr(A_ENS, 32'h1);
      repeat (6) @(negedge clk);
      wr(A_PSC, 32'h2);
      repeat (15) @(negedge clk);
      rd(A_CNT1, v); check("R3 before restart period", v, 1);
      rd(A_CNT1, v); check("R3 after restart period", v, 2);

      // R4: channel 1 clear while running
      wr(A_CLR, 32'h1);
      rd(A_CNT1, v); check("R4 clear cnt1", v, 0);

      // R5: enable set/clear registers
      wr(A_ENS, 32'h3);
      rd(A_ENS, v); check("R5 both on", v, 3);
      rd(A_ENC, v); check("R5 clear reg reads zero", v, 0);
      wr(A_ENC, 32'h3);
      rd(A_ENS, v); check("R5 both off", v, 0);

      // R2: field positions and dropped bits
      wr(A_PSC, 32'hFFFF_FFF9);
      rd(A_PSC, v); check("R2 fields", v, 32'h9);

      // R12: unmapped offsets
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      rd(8'h04, v); check("R12 read zero", v, 0);
      rd(A_PSC, v); check("R12 psc intact", v, 32'h9);
      rd(A_MSK, v); check("R12 mask intact", v, 0);
      rd(A_ENS, v); check("R12 enables intact", v, 0);

      finish_run();
   end
endmodule